// File: doc/BRIEF.md
# Serial Controller Port Latch

This block sits between a CPU register interface and up to four game pads. It has two serial ports. A write to the strobe register stores one strobe bit. When that stored bit goes from 1 to 0, each port copies a 24-bit frame into its own shift register. The frame holds the parallel button bytes of the pads on that port. After the copy, each read of a port returns one bit of its frame and moves the frame on by one position.

Each frame has three byte slots. The low slot always carries the first pad of the port. The middle slot carries a second pad only in four-player mode. Any slot with no pad in it is filled with a signature byte that names the port: 0x01 for port 0 and 0x02 for port 1. Software reads this signature to find out which pads are missing.

While the stored strobe is 1, no frame is loaded and nothing shifts. A read in this state returns bit 0 of the port's first pad as it is at that moment.

Top module: `pad_port_latch`

## Requirements
- R1: After reset the stored strobe is 0, both serial outputs are 0, and both shift registers hold all ones. A read made before any frame has been loaded therefore returns 1.
- R2: A frame is loaded only by a write of 0 while the stored strobe is 1. A write of 0 while the stored strobe is already 0 leaves both shift registers unchanged.
- R3: Every strobe write stores `strobe_val` as the new strobe value, and it is visible from the cycle after the write.
- R4: In two-player mode (`four_player`=0), port 0 loads {0x01, 0x01, pad0} and port 1 loads {0x02, 0x02, pad1}. The right-most byte is bits 7:0, the first bits read out. Pad k sits at `pads_i[8k+7:8k]`.
- R5: In four-player mode (`four_player`=1), port 0 loads {0x01, pad2, pad0} and port 1 loads {0x02, pad3, pad1}.
- R6: A read pulse on `rd_port[p]` while the strobe is 0 puts the shift register's bit 0 on `ser_out[p]` one cycle later. It then shifts the register right by one and fills the top bit with 1.
- R7: A read while the strobe is 1 puts bit 0 of the port's first pad, as it is live, on `ser_out[p]`. It does not shift the register.
- R8: Once all 24 frame bits have been read out, every further read returns 1 until the next frame is loaded.
- R9: A read on one port neither shifts the other port's register nor changes its output. Both ports may be read in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| four_player | input | 1 | 1 selects four-player frame layout |
| pads_i | input | 32 | Four button bytes, pad k at bits 8k+7:8k |
| strobe_wr | input | 1 | One-cycle write pulse to the strobe register |
| strobe_val | input | 1 | Strobe bit written by the pulse |
| rd_port | input | 2 | One-cycle read pulse per port |
| ser_out | output | 2 | Registered serial data bit per port |

## Verification
Results come out one cycle after their stimulus.

- A read pulse that is high across a rising edge shows its bit on `ser_out` just after that edge.
- A strobe write changes the stored strobe at its own edge. A write that loads a frame therefore shows up at the first read after it.

The bench drives pulses on the falling edge and keeps one queue of expected bits per port. The monitor marks a port as pending at the rising edge where the pulse is seen. It compares at the next falling edge, so each expected bit meets the output in exactly the cycle the output is due.

// File: rtl/pad_port_pkg.sv
package pad_port_pkg;
  localparam int unsigned DEF_PAD_W   = 8;
  localparam int unsigned DEF_SLOTS   = 3;
  localparam int unsigned NUM_PORTS   = 2;
  localparam int unsigned NUM_PADS    = 2 * NUM_PORTS;

  typedef enum logic {
    LAYOUT_TWO  = 1'b0,
    LAYOUT_FOUR = 1'b1
  } layout_e;
endpackage

// File: rtl/strobe_ctl.sv
module strobe_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_bit,
  output logic strobe_q,
  output logic latch_evt
);
  // falling transition of the stored strobe caused by a write
  assign latch_evt = wr_en & strobe_q & ~wr_bit;

  always_ff @(posedge clk) begin
    if (!rst_n)     strobe_q <= 1'b0;
    else if (wr_en) strobe_q <= wr_bit;
  end

  // R3
  strobe_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (strobe_q == $past(wr_bit)));

  // R2
  latch_falls_chk: assert property (@(posedge clk) disable iff (!rst_n)
    latch_evt |=> !strobe_q);
endmodule

// File: rtl/serial_port_shifter.sv
module serial_port_shifter
  import pad_port_pkg::*;
#(
  parameter int unsigned PAD_W    = DEF_PAD_W,
  parameter int unsigned SLOTS    = DEF_SLOTS,
  parameter int unsigned PORT_IDX = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strobe_q,
  input  logic             load,
  input  logic             rd,
  input  logic             four,
  input  logic [PAD_W-1:0] pad_lo,
  input  logic [PAD_W-1:0] pad_hi,
  output logic             ser
);
  localparam int unsigned FRAME_W = PAD_W * SLOTS;
  localparam logic [PAD_W-1:0] SIG = PAD_W'(1) << PORT_IDX;

  logic [FRAME_W-1:0] sh_q;
  logic [FRAME_W-1:0] frame_w;
  logic               shift_evt;

  function automatic logic [FRAME_W-1:0] make_frame(
    input layout_e          lay,
    input logic [PAD_W-1:0] lo,
    input logic [PAD_W-1:0] hi);
    logic [FRAME_W-1:0] f;
    for (int s = 0; s < int'(SLOTS); s++) f[s*PAD_W +: PAD_W] = SIG;
    f[0 +: PAD_W] = lo;
    if (lay == LAYOUT_FOUR && SLOTS > 1) f[PAD_W +: PAD_W] = hi;
    return f;
  endfunction

  assign frame_w   = make_frame(layout_e'(four), pad_lo, pad_hi);
  assign shift_evt = rd & ~strobe_q & ~load;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q <= '1;
      ser  <= 1'b0;
    end else begin
      if (load)           sh_q <= frame_w;
      else if (shift_evt) sh_q <= {1'b1, sh_q[FRAME_W-1:1]};
      if (rd)             ser  <= strobe_q ? pad_lo[0] : sh_q[0];
    end
  end

  // R4
  frame_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (sh_q == $past(frame_w)));

  // R6
  lsb_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift_evt |=> (ser == $past(sh_q[0])));

  // R8
  fill_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift_evt |=> sh_q[FRAME_W-1]);

  // R7
  hold_no_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && strobe_q && !load) |=> $stable(sh_q));

  // R9
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd && !load) |=> ($stable(sh_q) && $stable(ser)));
endmodule

// File: rtl/pad_port_latch.sv
module pad_port_latch
  import pad_port_pkg::*;
#(
  parameter int unsigned PAD_W = DEF_PAD_W,
  parameter int unsigned SLOTS = DEF_SLOTS
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        four_player,
  input  logic [NUM_PADS*PAD_W-1:0]   pads_i,
  input  logic                        strobe_wr,
  input  logic                        strobe_val,
  input  logic [NUM_PORTS-1:0]        rd_port,
  output logic [NUM_PORTS-1:0]        ser_out
);
  logic strobe_q;
  logic latch_evt;

  strobe_ctl u_strobe (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (strobe_wr),
    .wr_bit    (strobe_val),
    .strobe_q  (strobe_q),
    .latch_evt (latch_evt)
  );

  for (genvar p = 0; p < int'(NUM_PORTS); p++) begin : g_port
    serial_port_shifter #(
      .PAD_W    (PAD_W),
      .SLOTS    (SLOTS),
      .PORT_IDX (p)
    ) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .strobe_q (strobe_q),
      .load     (latch_evt),
      .rd       (rd_port[p]),
      .four     (four_player),
      .pad_lo   (pads_i[p*PAD_W +: PAD_W]),
      .pad_hi   (pads_i[(p+NUM_PORTS)*PAD_W +: PAD_W]),
      .ser      (ser_out[p])
    );
  end

  // R1
  reset_out_chk: assert property (@(posedge clk)
    !rst_n |=> (ser_out == '0 && !strobe_q));
endmodule

// File: tb/pad_port_latch_tb.sv
`timescale 1ns/1ps
module pad_port_latch_tb;
  localparam int PW = 8;
  localparam int FW = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          four_player = 1'b0;
  logic [4*PW-1:0] pads = '0;
  logic          strobe_wr = 1'b0;
  logic          strobe_val = 1'b0;
  logic [1:0]    rd_port = 2'b00;
  logic [1:0]    ser_out;

  pad_port_latch u_dut (
    .clk(clk), .rst_n(rst_n), .four_player(four_player), .pads_i(pads),
    .strobe_wr(strobe_wr), .strobe_val(strobe_val), .rd_port(rd_port),
    .ser_out(ser_out));

  always #2 clk = ~clk;

  typedef struct { logic val; string req; } item_t;
  item_t q0[$];
  item_t q1[$];
  int checks = 0;
  int errors = 0;
  logic [FW-1:0] m_sh0 = '1;
  logic [FW-1:0] m_sh1 = '1;
  logic m_strobe = 1'b0;
  logic pend0 = 1'b0;
  logic pend1 = 1'b0;
  bit   done = 1'b0;

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // bench-side frame layout, written from the requirements
  function automatic logic [FW-1:0] frame0(input logic fp, input logic [4*PW-1:0] p);
    return fp ? {8'h01, p[23:16], p[7:0]} : {8'h01, 8'h01, p[7:0]};
  endfunction
  function automatic logic [FW-1:0] frame1(input logic fp, input logic [4*PW-1:0] p);
    return fp ? {8'h02, p[31:24], p[15:8]} : {8'h02, 8'h02, p[15:8]};
  endfunction

  task automatic wr(input logic v);
    @(negedge clk);
    strobe_wr = 1'b1; strobe_val = v;
    if (m_strobe && !v) begin
      m_sh0 = frame0(four_player, pads);
      m_sh1 = frame1(four_player, pads);
    end
    m_strobe = v;
    @(negedge clk);
    strobe_wr = 1'b0;
  endtask

  task automatic rd(input logic do0, input logic do1, input string req);
    item_t it;
    @(negedge clk);
    rd_port = {do1, do0};
    if (do0) begin
      it.req = req;
      it.val = m_strobe ? pads[0] : m_sh0[0];
      if (!m_strobe) m_sh0 = {1'b1, m_sh0[FW-1:1]};
      q0.push_back(it);
    end
    if (do1) begin
      it.req = req;
      it.val = m_strobe ? pads[8] : m_sh1[0];
      if (!m_strobe) m_sh1 = {1'b1, m_sh1[FW-1:1]};
      q1.push_back(it);
    end
    @(negedge clk);
    rd_port = 2'b00;
  endtask

  // monitor: pending flag set at the capturing edge, compare at next falling edge
  always @(posedge clk) begin
    pend0 <= rd_port[0];
    pend1 <= rd_port[1];
  end

  always @(negedge clk) begin
    item_t it;
    if (pend0) begin
      if (q0.size() == 0) begin
        checks++; errors++;
        $display("FAIL R6: actual %b expected none (port0 queue empty)", ser_out[0]);
      end else begin
        it = q0.pop_front();
        check({it.req, " port0"}, ser_out[0], it.val);
      end
    end
    if (pend1) begin
      if (q1.size() == 0) begin
        checks++; errors++;
        $display("FAIL R6: actual %b expected none (port1 queue empty)", ser_out[1]);
      end else begin
        it = q1.pop_front();
        check({it.req, " port1"}, ser_out[1], it.val);
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset out0", ser_out[0], 1'b0);
    check("R1 reset out1", ser_out[1], 1'b0);
    rd(1'b1, 1'b1, "R1");

    pads = {8'hF0, 8'h0F, 8'h3C, 8'hA5};
    wr(1'b1);
    rd(1'b1, 1'b0, "R7");
    pads[0] = 1'b0;
    rd(1'b1, 1'b1, "R7");
    pads[0] = 1'b1;
    pads[8] = 1'b1;
    rd(1'b1, 1'b1, "R7");
    wr(1'b1);
    rd(1'b1, 1'b0, "R3");

    wr(1'b0);
    for (int i = 0; i < FW + 3; i++) rd(1'b1, 1'b0, (i < PW) ? "R6" : (i < FW) ? "R4" : "R8");
    for (int i = 0; i < 5; i++) rd(1'b0, 1'b1, "R9");

    pads = {8'h11, 8'h22, 8'h5A, 8'hC3};
    wr(1'b0);
    for (int i = 0; i < 6; i++) rd(1'b0, 1'b1, "R2");
    rd(1'b1, 1'b0, "R2");

    four_player = 1'b1;
    pads = {8'h96, 8'h69, 8'hE7, 8'h18};
    wr(1'b1);
    wr(1'b0);
    for (int i = 0; i < FW + 2; i++) rd(1'b1, 1'b1, (i < FW) ? "R5" : "R8");

    repeat (3) @(negedge clk);
    if (q0.size() != 0 || q1.size() != 0) begin
      checks++; errors++;
      $display("FAIL R6: actual %0d leftover expected 0", q0.size() + q1.size());
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule